// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Core

This block is a small multicycle processor that runs programs built from one instruction only. There is no opcode: every word that the program counter walks over is either an operand pointer or a jump destination. An instruction spans three consecutive memory words. The first is a pointer to the subtrahend, the second is a pointer to the minuend, which also receives the result, and the third is a jump destination. The core subtracts, writes the difference back over the minuend, and jumps when the difference is zero or negative. Otherwise it moves on to the word right after the instruction.

A step counter drives a single-port synchronous RAM with a one-cycle read latency. Each read takes two steps: one step presents the address and the next step captures the data. A program stops by jumping to address 0. When the counter finds the program counter at zero at the start of an instruction, the core raises its halted flag and issues no further memory cycles until reset. Zeroing, addition, copying and unconditional jumps are all written as short chains of this one instruction.

Top module: `sbn_core`

## Requirements
- R1: An instruction is the three words at PC, PC+1 and PC+2, read in that order: subtrahend pointer, minuend pointer, jump destination. After reset, the first memory access is a read of address 1.
- R2: The core writes mem[minuend pointer] - mem[subtrahend pointer], modulo 2^16, back to the minuend pointer. The write takes exactly one cycle with mem_we_o high, and there is exactly one such cycle per instruction.
- R3: When the 16-bit difference is zero or has bit 15 set, PC becomes the jump destination. The decision uses the difference computed inside the core, not a value read back from memory. For example, 0x8000 - 1 = 0x7FFF is positive, so it does not jump.
- R4: When the difference is positive, PC becomes PC+3, and the next instruction starts at the word after the jump destination.
- R5: If PC is 0 when an instruction is about to start, halted_o rises one cycle later. It then stays high until reset, and mem_en_o stays low for the whole time.
- R6: While reset is held, halted_o and mem_we_o are low. Reset sets PC to 1.
- R7: Every instruction takes exactly 12 clock cycles. A program that runs N instructions and then jumps to 0 shows halted_o high after 12*N+1 rising edges from reset release.
- R8: The jump destination is read from memory after the write-back. An instruction whose minuend pointer names its own destination word therefore jumps to the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Write strobe, valid with mem_en_o |
| mem_en_o | output | 1 | Memory access enable; a read when mem_we_o is low |
| mem_rdata_i | input | 16 | Read data, valid one cycle after an enabled read |
| halted_o | output | 1 | Core has stopped at PC 0 |

## Verification
Two functions share one instruction slot and can collide: storing the difference and fetching the jump destination, which is read in the steps that follow the store. The collision is forced with an instruction whose minuend pointer is its own third word, and the computed difference is zero. The run passes only if the core stops at once, because it jumped to the freshly written 0. If it ran a stale destination, it would land on a trap instruction that changes a sentinel word, and the bench checks the sentinel. The same difference also feeds the jump decision, so the sign-wrap case (0x8000 - 1) and a negative difference are judged by which code path the program takes, seen through the final memory contents and the cycle count.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
  typedef enum logic [3:0] {
    ST_CHECK,
    ST_RD_PA,
    ST_LT_PA,
    ST_RD_A,
    ST_LT_A,
    ST_RD_PB,
    ST_LT_PB,
    ST_RD_B,
    ST_LT_B,
    ST_WR,
    ST_RD_T,
    ST_LT_T,
    ST_HALT
  } step_e;

  typedef enum logic [1:0] {
    ASEL_PC,
    ASEL_A,
    ASEL_B
  } asel_e;
endpackage

// File: rtl/sbn_sub.sv
module sbn_sub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] minu_i,
  input  logic [DW-1:0] subt_i,
  output logic [DW-1:0] diff_o,
  output logic          le_o
);
  always_comb begin
    diff_o = minu_i - subt_i;
    le_o   = diff_o[DW-1] | ~|diff_o;
  end
endmodule

// File: rtl/sbn_seq.sv
module sbn_seq
  import sbn_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pc_zero_i,
  output step_e step_o,
  output asel_e asel_o,
  output logic  mem_en_o,
  output logic  mem_we_o,
  output logic  halted_o
);
  step_e step_q, step_d;

  always_comb begin
    unique case (step_q)
      ST_CHECK: step_d = pc_zero_i ? ST_HALT : ST_RD_PA;
      ST_RD_PA: step_d = ST_LT_PA;
      ST_LT_PA: step_d = ST_RD_A;
      ST_RD_A:  step_d = ST_LT_A;
      ST_LT_A:  step_d = ST_RD_PB;
      ST_RD_PB: step_d = ST_LT_PB;
      ST_LT_PB: step_d = ST_RD_B;
      ST_RD_B:  step_d = ST_LT_B;
      ST_LT_B:  step_d = ST_WR;
      ST_WR:    step_d = ST_RD_T;
      ST_RD_T:  step_d = ST_LT_T;
      ST_LT_T:  step_d = ST_CHECK;
      default:  step_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_CHECK;
    else         step_q <= step_d;
  end

  always_comb begin
    mem_en_o = 1'b0;
    mem_we_o = 1'b0;
    asel_o   = ASEL_PC;
    unique case (step_q)
      ST_RD_PA, ST_RD_PB, ST_RD_T: mem_en_o = 1'b1;
      ST_RD_A: begin
        mem_en_o = 1'b1;
        asel_o   = ASEL_A;
      end
      ST_RD_B: begin
        mem_en_o = 1'b1;
        asel_o   = ASEL_B;
      end
      ST_WR: begin
        mem_en_o = 1'b1;
        mem_we_o = 1'b1;
        asel_o   = ASEL_B;
      end
      default: ;
    endcase
  end

  assign step_o   = step_q;
  assign halted_o = (step_q == ST_HALT);

  assert_halt_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  assert_halt_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_en_o);
  assert_halt_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_CHECK && pc_zero_i) |=> halted_o);
  assert_single_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  assert_instr_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_LT_T) |=> (step_q == ST_CHECK));
endmodule

// File: rtl/sbn_dp.sv
module sbn_dp
  import sbn_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  step_e         step_i,
  input  asel_e         asel_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          pc_zero_o
);
  localparam logic [DW-1:0] PcReset = DW'(1);
  localparam logic [DW-1:0] One     = DW'(1);

  logic [DW-1:0] pc_q, a_ptr_q, b_ptr_q, a_val_q, res_q;
  logic          le_q;
  logic [DW-1:0] diff;
  logic          diff_le;

  sbn_sub #(.DW(DW)) u_sub (
    .minu_i (rdata_i),
    .subt_i (a_val_q),
    .diff_o (diff),
    .le_o   (diff_le)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= PcReset;
      a_ptr_q <= '0;
      b_ptr_q <= '0;
      a_val_q <= '0;
      res_q   <= '0;
      le_q    <= 1'b0;
    end else begin
      unique case (step_i)
        ST_LT_PA: begin
          a_ptr_q <= rdata_i;
          pc_q    <= pc_q + One;
        end
        ST_LT_A: a_val_q <= rdata_i;
        ST_LT_PB: begin
          b_ptr_q <= rdata_i;
          pc_q    <= pc_q + One;
        end
        ST_LT_B: begin
          res_q <= diff;
          le_q  <= diff_le;
        end
        ST_LT_T: pc_q <= le_q ? rdata_i : pc_q + One;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (asel_i)
      ASEL_A:  addr_o = a_ptr_q;
      ASEL_B:  addr_o = b_ptr_q;
      default: addr_o = pc_q;
    endcase
  end

  assign wdata_o   = res_q;
  assign pc_zero_o = (pc_q == '0);

  assert_jump_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_LT_T && le_q) |=> (pc_q == $past(rdata_i)));
  assert_fall_through_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_LT_T && !le_q) |=> (pc_q == $past(pc_q) + One));
  assert_pc_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != ST_LT_PA && step_i != ST_LT_PB && step_i != ST_LT_T) |=> $stable(pc_q));
endmodule

// File: rtl/sbn_core.sv
module sbn_core
  import sbn_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_en_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          halted_o
);
  step_e step;
  asel_e asel;
  logic  pc_zero;

  sbn_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pc_zero_i (pc_zero),
    .step_o    (step),
    .asel_o    (asel),
    .mem_en_o  (mem_en_o),
    .mem_we_o  (mem_we_o),
    .halted_o  (halted_o)
  );

  sbn_dp #(.DW(DW)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .asel_i    (asel),
    .rdata_i   (mem_rdata_i),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .pc_zero_o (pc_zero)
  );

  assert_write_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);
endmodule

// File: tb/sbn_core_bench.sv
`timescale 1ns/1ps
module sbn_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr, wdata, rdata;
  logic        we, en, halted;
  logic        ld_en = 1'b0, clr = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [256];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sbn_core u_sbn_core (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_en_o(en), .mem_rdata_i(rdata), .halted_o(halted)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (en) begin
      if (we) mem[addr[7:0]] <= wdata;
      rdata <= mem[addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_test();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic ld(input int a, input int d);
    @(negedge clk);
    ld_en = 1'b1;
    ld_addr = 8'(a);
    ld_data = 16'(d);
  endtask

  task automatic ins(input int base, input int a, input int b, input int t);
    ld(base, a);
    ld(base + 1, b);
    ld(base + 2, t);
  endtask

  task automatic run(input string req, input int exp_cyc, input int exp_wr);
    int cyc = 0, wr = 0, first_addr = -1, quiet_bad = 0;
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    chk(halted == 1'b0 && we == 1'b0, "R6", "outputs during reset", {halted, we}, 0);
    rst_n = 1'b1;
    while (cyc < 5000) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (en && first_addr < 0) first_addr = int'(addr);
      if (we) wr++;
      if (halted) break;
    end
    chk(halted, "R5", {req, " halt reached"}, halted, 1);
    chk(first_addr == 1, "R1", "first fetch address", first_addr, 1);
    chk(cyc == exp_cyc, "R7", {req, " cycles to halt"}, cyc, exp_cyc);
    chk(wr == exp_wr, "R2", {req, " write cycles"}, wr, exp_wr);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (en || !halted) quiet_bad++;
    end
    chk(quiet_bad == 0, "R5", {req, " quiet after halt"}, quiet_bad, 0);
  endtask

  task automatic t_zero();
    start_test();
    ins(1, 100, 100, 4);
    ins(4, 101, 101, 0);
    ld(100, 37);
    run("R2 zero", 25, 2);
    chk(mem[100] == 16'h0, "R2", "zeroed word", mem[100], 0);
  endtask

  task automatic t_add();
    start_test();
    ins(1, 100, 101, 4);
    ins(4, 101, 102, 7);
    ins(7, 101, 101, 0);
    ld(100, 5); ld(102, 7);
    run("R4 add", 37, 3);
    chk(mem[102] == 16'd12, "R4", "sum", mem[102], 12);
    chk(mem[101] == 16'd0, "R3", "temp restored", mem[101], 0);
  endtask

  task automatic t_move();
    start_test();
    ins(1, 103, 103, 4);
    ins(4, 100, 101, 7);
    ins(7, 101, 103, 10);
    ins(10, 101, 101, 0);
    ld(100, 42); ld(103, 99);
    run("R2 move", 49, 4);
    chk(mem[103] == 16'd42, "R2", "moved value", mem[103], 42);
    chk(mem[100] == 16'd42, "R2", "source kept", mem[100], 42);
  endtask

  task automatic t_jump();
    start_test();
    ins(1, 101, 101, 10);
    ins(4, 105, 104, 0);
    ins(10, 101, 101, 0);
    ld(104, 9); ld(105, 1);
    run("R3 jump", 25, 2);
    chk(mem[104] == 16'd9, "R3", "skipped sentinel", mem[104], 9);
  endtask

  task automatic t_negative();
    start_test();
    ins(1, 102, 100, 13);
    ins(4, 105, 104, 0);
    ins(13, 101, 101, 0);
    ld(100, 3); ld(102, 5); ld(104, 9); ld(105, 1);
    run("R3 negative", 25, 2);
    chk(mem[100] == 16'hFFFE, "R3", "negative diff", mem[100], 16'hFFFE);
    chk(mem[104] == 16'd9, "R3", "negative jump sentinel", mem[104], 9);
  endtask

  task automatic t_wrap();
    start_test();
    ins(1, 105, 100, 13);
    ins(4, 101, 101, 0);
    ins(13, 105, 104, 0);
    ld(100, 16'h8000); ld(104, 9); ld(105, 1);
    run("R4 wrap", 25, 2);
    chk(mem[100] == 16'h7FFF, "R3", "wrapped diff", mem[100], 16'h7FFF);
    chk(mem[104] == 16'd9, "R4", "no jump on wrap", mem[104], 9);
  endtask

  task automatic t_selfmod();
    start_test();
    ins(1, 110, 3, 10);
    ins(10, 105, 104, 0);
    ld(110, 10); ld(104, 9); ld(105, 1);
    run("R8 self target", 13, 1);
    chk(mem[3] == 16'd0, "R8", "rewritten target", mem[3], 0);
    chk(mem[104] == 16'd9, "R8", "stale target unused", mem[104], 9);
  endtask

  initial begin
    t_zero();
    t_add();
    t_move();
    t_jump();
    t_negative();
    t_wrap();
    t_selfmod();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule